// File: doc/BRIEF.md
# SPI Interrupt and Standby Controller

This block is the interrupt and low-power slice of an SPI peripheral. It holds one flag bit and one enable bit for each interrupt source. The sources are data-register-empty, transmit-complete, receive-complete and error. Each source's flag is set by a one-cycle event pulse from the transfer logic and is cleared by software writing 1 to it. The enables are changed through two separate write ports, one that sets bits and one that clears them. Every source whose flag and enable are both set drives one shared interrupt request line. Software finds the cause by reading the flags.

While the device sleeps, the block decides what happens to the SPI core clock and what may wake the device. The decision depends on the master/slave mode and a run-in-standby bit:

- **Master, run-in-standby set:** the clock keeps running, and any pending interrupt requests a wake.
- **Master, run-in-standby clear:** the clock stops once the transfer in progress has finished, and any pending interrupt requests a wake.
- **Slave, run-in-standby set:** the clock keeps running, and only receive-complete requests a wake.
- **Slave, run-in-standby clear:** the clock stops and every reception is discarded. This includes a frame that was already in progress when sleep began.

The clock enable output is registered.

Top module: `spi_irq_standby_ctrl`

## Requirements
- R1: A cycle with `en_set_we` high sets every enable bit whose `en_set_data` bit is 1 at the next clock edge. Bits written 0 keep their value. If the same bit is written 1 on both enable ports in one cycle, the bit ends up set.
- R2: A cycle with `en_clr_we` high clears every enable bit whose `en_clr_data` bit is 1, unless the set port sets that bit in the same cycle. Bits written 0 keep their value.
- R3: A high `src_evt` bit sets that flag at the next edge. The source bits are: bit 0 data-register-empty, bit 1 transmit-complete, bit 2 receive-complete, bit 3 error.
  - A cycle with `flag_clr_we` high clears every flag whose `flag_clr_data` bit is 1, and bits written 0 keep their value.
  - When an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: `irq` is high in exactly those cycles in which some source has both its flag and its enable set. It stays high until that flag is cleared or that source is disabled.
- R5: At a clock edge with `rst` high, all flags and all enables clear, and `core_clk_en` becomes 1.
- R6: With `is_master`=1 and `run_stdby`=1, `core_clk_en` stays 1 in sleep state 01 (idle) and in sleep state 10 (standby). In either state, `wake` is high whenever any source is pending, meaning its flag and enable are both set.
- R7: With `is_master`=1 and `run_stdby`=0, `core_clk_en` stays 1 while `xfer_busy` is high. It falls at the first edge at which the sleep state is nonzero and `xfer_busy` is low. During sleep, `wake` follows any pending source.
- R8: With `is_master`=0 and `run_stdby`=1, `core_clk_en` stays 1 during sleep. `wake` is high only while receive-complete (bit 2) is pending. Other pending sources leave `wake` low.
- R9: With `is_master`=0 and `run_stdby`=0, while the sleep state is nonzero:
  - `rx_drop` is high, `wake` is low, and `core_clk_en` is 0 from the next edge on.
  - Receive-complete events do not set flag bit 2.
  - After wake-up, `rx_drop` stays high, and receive-complete events stay ignored, until the first edge at which `xfer_busy` is low.
- R10: `wake` is low whenever the sleep state is 00 (active).
- R11: `core_clk_en` returns to 1 at the first edge at which the sleep state is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_set_we | input | 1 | Write strobe for the enable-set port |
| en_set_data | input | NSRC | 1 bits set the matching enables |
| en_clr_we | input | 1 | Write strobe for the enable-clear port |
| en_clr_data | input | NSRC | 1 bits clear the matching enables |
| flag_clr_we | input | 1 | Write strobe for the flag-clear port |
| flag_clr_data | input | NSRC | 1 bits clear the matching flags |
| src_evt | input | NSRC | One-cycle set pulses, one per source |
| xfer_busy | input | 1 | A frame is being shifted |
| sleep_st | input | 2 | 00 active, 01 idle sleep, 10 standby sleep |
| is_master | input | 1 | 1 master, 0 slave |
| run_stdby | input | 1 | Run-in-standby control |
| flags | output | NSRC | Interrupt flag state |
| enables | output | NSRC | Interrupt enable state |
| irq | output | 1 | Shared interrupt request |
| wake | output | 1 | Wake request during sleep |
| core_clk_en | output | 1 | Registered core clock enable |
| rx_drop | output | 1 | Receptions are being discarded |

## Verification
The assertions take the following for granted about the inputs:
- `src_evt` bits are single-cycle pulses.
- `is_master` and `run_stdby` change only while the sleep state is 00.
- Sleep state 11 is never driven.
- `xfer_busy` does not rise while the core clock is gated.

The bench changes the mode bits only right after a reset, in the active state. It raises events for one cycle at a time, and drives `xfer_busy` only before or during sleep entry. Every input change is made a fraction of a cycle after a rising edge.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int SLEEP_W = 2;
  localparam logic [SLEEP_W-1:0] SLP_ACTIVE  = 2'b00;
  localparam logic [SLEEP_W-1:0] SLP_IDLE    = 2'b01;
  localparam logic [SLEEP_W-1:0] SLP_STANDBY = 2'b10;

  typedef enum logic [1:0] {
    POL_RUN      = 2'b00,
    POL_FINISH   = 2'b01,
    POL_RXONLY   = 2'b10,
    POL_DISCARD  = 2'b11
  } policy_e;

  function automatic logic f_sleeping(input logic [SLEEP_W-1:0] st);
    return st != SLP_ACTIVE;
  endfunction

  function automatic policy_e f_policy(input logic master, input logic rstdby);
    if (master) return rstdby ? POL_RUN : POL_FINISH;
    return rstdby ? POL_RXONLY : POL_DISCARD;
  endfunction

  function automatic logic f_clk_next(input policy_e pol, input logic sleeping,
                                      input logic busy);
    logic run;
    case (pol)
      POL_RUN:     run = 1'b1;
      POL_RXONLY:  run = 1'b1;
      POL_FINISH:  run = !sleeping || busy;
      default:     run = !sleeping;
    endcase
    return run;
  endfunction

endpackage

// File: rtl/spi_irq_state.sv
module spi_irq_state #(
  parameter int NSRC    = 4,
  parameter int RXC_BIT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_set_we,
  input  logic [NSRC-1:0] en_set_data,
  input  logic            en_clr_we,
  input  logic [NSRC-1:0] en_clr_data,
  input  logic            flag_clr_we,
  input  logic [NSRC-1:0] flag_clr_data,
  input  logic [NSRC-1:0] src_evt,
  input  logic            rx_drop,
  output logic [NSRC-1:0] evt_eff,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] enables
);

  logic [NSRC-1:0] set_mask;
  logic [NSRC-1:0] clr_mask;
  logic [NSRC-1:0] fclr_mask;

  assign set_mask  = en_set_we   ? en_set_data   : '0;
  assign clr_mask  = en_clr_we   ? en_clr_data   : '0;
  assign fclr_mask = flag_clr_we ? flag_clr_data : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == RXC_BIT) begin : g_rx
      assign evt_eff[i] = src_evt[i] && !rx_drop;
    end else begin : g_other
      assign evt_eff[i] = src_evt[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i]   <= 1'b0;
        enables[i] <= 1'b0;
      end else begin
        flags[i]   <= evt_eff[i] || (flags[i] && !fclr_mask[i]);
        enables[i] <= set_mask[i] || (enables[i] && !clr_mask[i]);
      end
    end
  end

endmodule

// File: rtl/spi_sleep_policy.sv
module spi_sleep_policy
  import spi_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [SLEEP_W-1:0] sleep_st,
  input  logic               is_master,
  input  logic               run_stdby,
  input  logic               xfer_busy,
  output policy_e            policy,
  output logic               sleeping,
  output logic               core_clk_en,
  output logic               rx_drop
);

  logic drop_cond;
  logic drop_hold;

  assign policy    = f_policy(is_master, run_stdby);
  assign sleeping  = f_sleeping(sleep_st);
  assign drop_cond = sleeping && (policy == POL_DISCARD);
  assign rx_drop   = drop_cond || drop_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_clk_en <= 1'b1;
      drop_hold   <= 1'b0;
    end else begin
      core_clk_en <= f_clk_next(policy, sleeping, xfer_busy);
      drop_hold   <= drop_cond || (drop_hold && xfer_busy);
    end
  end

endmodule

// File: rtl/spi_irq_out.sv
module spi_irq_out
  import spi_irq_pkg::*;
#(
  parameter int NSRC    = 4,
  parameter int RXC_BIT = 2
) (
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] enables,
  input  policy_e         policy,
  input  logic            sleeping,
  output logic [NSRC-1:0] pending,
  output logic            irq,
  output logic            wake
);

  assign pending = flags & enables;
  assign irq     = |pending;

  always_comb begin
    wake = 1'b0;
    if (sleeping) begin
      case (policy)
        POL_RUN, POL_FINISH: wake = |pending;
        POL_RXONLY:          wake = pending[RXC_BIT];
        default:             wake = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/spi_irq_standby_ctrl.sv
module spi_irq_standby_ctrl
  import spi_irq_pkg::*;
#(
  parameter int NSRC    = 4,
  parameter int RXC_BIT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_set_we,
  input  logic [NSRC-1:0]    en_set_data,
  input  logic               en_clr_we,
  input  logic [NSRC-1:0]    en_clr_data,
  input  logic               flag_clr_we,
  input  logic [NSRC-1:0]    flag_clr_data,
  input  logic [NSRC-1:0]    src_evt,
  input  logic               xfer_busy,
  input  logic [SLEEP_W-1:0] sleep_st,
  input  logic               is_master,
  input  logic               run_stdby,
  output logic [NSRC-1:0]    flags,
  output logic [NSRC-1:0]    enables,
  output logic               irq,
  output logic               wake,
  output logic               core_clk_en,
  output logic               rx_drop
);

  policy_e         policy;
  logic            sleeping;
  logic [NSRC-1:0] evt_eff;
  logic [NSRC-1:0] pending;

  spi_sleep_policy u_policy (
    .clk         (clk),
    .rst         (rst),
    .sleep_st    (sleep_st),
    .is_master   (is_master),
    .run_stdby   (run_stdby),
    .xfer_busy   (xfer_busy),
    .policy      (policy),
    .sleeping    (sleeping),
    .core_clk_en (core_clk_en),
    .rx_drop     (rx_drop)
  );

  spi_irq_state #(.NSRC(NSRC), .RXC_BIT(RXC_BIT)) u_state (
    .clk           (clk),
    .rst           (rst),
    .en_set_we     (en_set_we),
    .en_set_data   (en_set_data),
    .en_clr_we     (en_clr_we),
    .en_clr_data   (en_clr_data),
    .flag_clr_we   (flag_clr_we),
    .flag_clr_data (flag_clr_data),
    .src_evt       (src_evt),
    .rx_drop       (rx_drop),
    .evt_eff       (evt_eff),
    .flags         (flags),
    .enables       (enables)
  );

  spi_irq_out #(.NSRC(NSRC), .RXC_BIT(RXC_BIT)) u_out (
    .flags    (flags),
    .enables  (enables),
    .policy   (policy),
    .sleeping (sleeping),
    .pending  (pending),
    .irq      (irq),
    .wake     (wake)
  );

endmodule

// File: rtl/spi_irq_standby_chk.sv
module spi_irq_standby_chk #(
  parameter int NSRC    = 4,
  parameter int RXC_BIT = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            en_set_we,
  input logic [NSRC-1:0] en_set_data,
  input logic            en_clr_we,
  input logic [NSRC-1:0] en_clr_data,
  input logic [NSRC-1:0] evt_eff,
  input logic [NSRC-1:0] flags,
  input logic [NSRC-1:0] enables,
  input logic            irq,
  input logic            wake,
  input logic            xfer_busy,
  input logic [1:0]      sleep_st,
  input logic            is_master,
  input logic            run_stdby,
  input logic            core_clk_en,
  input logic            rx_drop
);

  a_r1_set_takes: assert property (@(posedge clk) disable iff (rst)
    en_set_we |=> ((enables & $past(en_set_data)) == $past(en_set_data)));

  a_r2_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (en_clr_we && !en_set_we) |=> ((enables & $past(en_clr_data)) == '0));

  a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
    (evt_eff != '0) |=> ((flags & $past(evt_eff)) == $past(evt_eff)));

  a_r4_irq_matches: assert property (@(posedge clk) disable iff (rst)
    irq == ((flags & enables) != '0));

  a_r5_reset_state: assert property (@(posedge clk)
    rst |=> (flags == '0 && enables == '0 && core_clk_en));

  a_r7_busy_keeps_clock: assert property (@(posedge clk) disable iff (rst)
    (is_master && !run_stdby && xfer_busy) |=> core_clk_en);

  a_r8_slave_wake_rx_only: assert property (@(posedge clk) disable iff (rst)
    (!is_master && run_stdby && wake) |-> (flags[RXC_BIT] && enables[RXC_BIT]));

  a_r9_no_rx_flag_on_drop: assert property (@(posedge clk) disable iff (rst)
    rx_drop |=> !(flags[RXC_BIT] && !$past(flags[RXC_BIT])));

  a_r10_no_wake_awake: assert property (@(posedge clk) disable iff (rst)
    (sleep_st == 2'b00) |-> !wake);

  a_r11_clock_back: assert property (@(posedge clk) disable iff (rst)
    (sleep_st == 2'b00) |=> core_clk_en);

endmodule

bind spi_irq_standby_ctrl spi_irq_standby_chk #(.NSRC(NSRC), .RXC_BIT(RXC_BIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_set_we   (en_set_we),
  .en_set_data (en_set_data),
  .en_clr_we   (en_clr_we),
  .en_clr_data (en_clr_data),
  .evt_eff     (evt_eff),
  .flags       (flags),
  .enables     (enables),
  .irq         (irq),
  .wake        (wake),
  .xfer_busy   (xfer_busy),
  .sleep_st    (sleep_st),
  .is_master   (is_master),
  .run_stdby   (run_stdby),
  .core_clk_en (core_clk_en),
  .rx_drop     (rx_drop)
);

// File: tb/tb_spi_irq_standby_ctrl.sv
module tb_spi_irq_standby_ctrl;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         en_set_we, en_clr_we, flag_clr_we;
  logic [N-1:0] en_set_data, en_clr_data, flag_clr_data, src_evt;
  logic         xfer_busy, is_master, run_stdby;
  logic [1:0]   sleep_st;
  logic [N-1:0] flags, enables;
  logic         irq, wake, core_clk_en, rx_drop;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spi_irq_standby_ctrl #(.NSRC(N), .RXC_BIT(2)) dut (
    .clk(clk), .rst(rst),
    .en_set_we(en_set_we), .en_set_data(en_set_data),
    .en_clr_we(en_clr_we), .en_clr_data(en_clr_data),
    .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
    .src_evt(src_evt), .xfer_busy(xfer_busy), .sleep_st(sleep_st),
    .is_master(is_master), .run_stdby(run_stdby),
    .flags(flags), .enables(enables), .irq(irq), .wake(wake),
    .core_clk_en(core_clk_en), .rx_drop(rx_drop)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    en_set_we = 0; en_set_data = '0; en_clr_we = 0; en_clr_data = '0;
    flag_clr_we = 0; flag_clr_data = '0; src_evt = '0;
  endtask

  task automatic do_reset(input logic m, input logic rs);
    idle_inputs();
    xfer_busy = 0; sleep_st = 2'b00; is_master = m; run_stdby = rs;
    rst = 1; step(); step(); rst = 0;
  endtask

  task automatic set_en(input logic [N-1:0] d);
    en_set_we = 1; en_set_data = d; step(); en_set_we = 0; en_set_data = '0;
  endtask

  task automatic pulse(input logic [N-1:0] d);
    src_evt = d; step(); src_evt = '0;
  endtask

  task automatic t_reset();
    do_reset(1, 1);
    set_en(4'hF); pulse(4'hF);
    rst = 1; step(); rst = 0;
    chk("R5 flags", 8'(flags), 8'h0);
    chk("R5 enables", 8'(enables), 8'h0);
    chk("R5 clk_en", 8'(core_clk_en), 8'h1);
    chk("R5 irq", 8'(irq), 8'h0);
  endtask

  task automatic t_enables();
    do_reset(1, 1);
    set_en(4'b0101);
    chk("R1 set", 8'(enables), 8'h5);
    en_set_we = 1; en_set_data = '0; step(); en_set_we = 0;
    chk("R1 zero no effect", 8'(enables), 8'h5);
    en_clr_we = 1; en_clr_data = 4'b0001; step(); en_clr_we = 0;
    chk("R2 clear", 8'(enables), 8'h4);
    en_clr_we = 1; en_clr_data = '0; step(); en_clr_we = 0;
    chk("R2 zero no effect", 8'(enables), 8'h4);
    en_set_we = 1; en_set_data = 4'b1000; en_clr_we = 1; en_clr_data = 4'b1000;
    step(); idle_inputs();
    chk("R1 set beats clear", 8'(enables), 8'hC);
  endtask

  task automatic t_flags();
    do_reset(1, 1);
    set_en(4'b1100);
    pulse(4'b0010);
    chk("R3 flag set", 8'(flags), 8'h2);
    chk("R4 not enabled", 8'(irq), 8'h0);
    set_en(4'b0010);
    chk("R4 irq on", 8'(irq), 8'h1);
    flag_clr_we = 1; flag_clr_data = '0; step(); flag_clr_we = 0;
    chk("R3 zero clear no effect", 8'(flags), 8'h2);
    src_evt = 4'b1000; flag_clr_we = 1; flag_clr_data = 4'b1000; step(); idle_inputs();
    chk("R3 set beats clear", 8'(flags), 8'hA);
    flag_clr_we = 1; flag_clr_data = 4'b0010; step(); idle_inputs();
    chk("R3 flag cleared", 8'(flags), 8'h8);
    chk("R4 irq held by bit3", 8'(irq), 8'h1);
    en_clr_we = 1; en_clr_data = 4'b1000; step(); idle_inputs();
    chk("R4 disable drops irq", 8'(irq), 8'h0);
  endtask

  task automatic t_master_run();
    do_reset(1, 1);
    set_en(4'hF);
    sleep_st = 2'b10; step(); step();
    chk("R6 standby clk", 8'(core_clk_en), 8'h1);
    chk("R6 no wake idle", 8'(wake), 8'h0);
    sleep_st = 2'b01; step();
    chk("R6 idle clk", 8'(core_clk_en), 8'h1);
    pulse(4'b0001);
    chk("R6 wake", 8'(wake), 8'h1);
  endtask

  task automatic t_master_finish();
    do_reset(1, 0);
    set_en(4'hF);
    xfer_busy = 1; sleep_st = 2'b10; step(); step();
    chk("R7 busy keeps clk", 8'(core_clk_en), 8'h1);
    xfer_busy = 0; step();
    chk("R7 gated after xfer", 8'(core_clk_en), 8'h0);
    pulse(4'b1000);
    chk("R7 wake", 8'(wake), 8'h1);
    sleep_st = 2'b00; #1;
    chk("R10 wake low awake", 8'(wake), 8'h0);
    step();
    chk("R11 clk back", 8'(core_clk_en), 8'h1);
  endtask

  task automatic t_slave_run();
    do_reset(0, 1);
    set_en(4'hF);
    sleep_st = 2'b10; step();
    pulse(4'b0010);
    chk("R8 tx no wake", 8'(wake), 8'h0);
    chk("R8 irq still", 8'(irq), 8'h1);
    pulse(4'b0100);
    chk("R8 rx wake", 8'(wake), 8'h1);
    chk("R8 clk runs", 8'(core_clk_en), 8'h1);
  endtask

  task automatic t_slave_discard();
    do_reset(0, 0);
    set_en(4'hF);
    xfer_busy = 1; sleep_st = 2'b10; #1;
    chk("R9 drop on", 8'(rx_drop), 8'h1);
    step();
    chk("R9 clk gated", 8'(core_clk_en), 8'h0);
    pulse(4'b0100);
    chk("R9 rx flag dropped", 8'(flags), 8'h0);
    pulse(4'b1000);
    chk("R9 no wake", 8'(wake), 8'h0);
    sleep_st = 2'b00; step();
    chk("R9 drop held", 8'(rx_drop), 8'h1);
    pulse(4'b0100);
    chk("R9 in-flight dropped", 8'(flags), 8'h8);
    xfer_busy = 0; step();
    chk("R9 drop released", 8'(rx_drop), 8'h0);
    pulse(4'b0100);
    chk("R9 rx accepted", 8'(flags), 8'hC);
  endtask

  initial begin
    do_reset(1, 1);
    t_reset();
    t_enables();
    t_flags();
    t_master_run();
    t_master_finish();
    t_slave_run();
    t_slave_discard();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule